// File: doc/BRIEF.md
# Half-Duplex Single-Wire UART

This block runs asynchronous serial framing over a single shared wire that an external resistor pulls high. Both directions use the same line. The block drives it in open-drain fashion: it either pulls the line low or releases it, and it never drives it high. A byte-wide transmit handshake and a received-byte pulse connect it to the rest of the chip. Each frame is a low start bit, eight data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits.

Because every bit the block sends also reaches its own receiver, the block compares the line with the intended level at the middle of each bit. A mismatch abandons the byte and signals a collision. The receiver drops the block's own frames, so only traffic from other nodes appears at the received-byte output. A transmission starts only after the line has stayed high for one whole character time. A low level that lasts one character time or longer is reported as a break and does not produce a byte. A listen input turns the block into a pure monitor that never pulls the line. The bit time comes from one of three preset rates, used for LIN and K-Line style buses, or from a custom cycle count.

Top module: `swu_top`

## Requirements
- R1: An accepted byte (`tx_valid` and `tx_ready` high at a rising edge) is sent through `line_pull_low` (1 = pull low, 0 = release) starting at the next cycle. The bits go out in this order: start (low), data bits 0 to 7, the parity bit if `par_en` is set, then one stop bit, or two if `two_stop` is set (high). Each bit lasts one bit time of clock cycles.
- R2: With `par_en`=1 the parity bit makes the total count of ones in the data and parity bits even when `par_odd`=0 and odd when `par_odd`=1. This holds for sending and for checking received bytes.
- R3: A frame sent by another node produces a one-cycle `rx_valid` with the data on `rx_data`. `rx_parity_err` is set exactly when parity is enabled and the received parity bit is wrong.
- R4: If the stop bit is sampled low and the line then returns high before one character time of low has passed, the byte is still delivered, with `rx_frame_err`=1.
- R5: A continuous low level lasting one character time produces a single `line_break` pulse, and that frame gives no `rx_valid`. One character time is the bit time multiplied by (10 + `par_en` + `two_stop`). An all-zero byte with a high stop bit is a normal byte and not a break.
- R6: Frames the block sends itself never produce `rx_valid`.
- R7: At the middle of each bit being sent, the block compares the line with the intended level. A mismatch gives a one-cycle `collision` pulse, releases the line in that same cycle, and abandons the byte.
- R8: `tx_ready` is high only when no frame is being sent, listen mode is off, and the line has been high for at least one character time since its last low level. Time spent in reset does not count towards this.
- R9: While `listen_en` is high the block never pulls the line low and `tx_ready` stays low. Reception still works. If `listen_en` rises in the middle of a frame being sent, the line is released at the next clock edge.
- R10: `baud_sel` chooses the bit time in clock cycles: 0 gives round(CLK_HZ/9600), 1 gives round(CLK_HZ/19200), 2 gives round(CLK_HZ/10400), and 3 takes the value on `custom_ticks`. The bit time must be at least 8 cycles.
- R11: After reset the block releases the line and holds `tx_ready`, `rx_valid`, `collision` and `line_break` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_sel | input | 2 | Bit-time select: three presets or custom |
| custom_ticks | input | 16 | Bit time in clock cycles when baud_sel is 3 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when set, even when clear |
| two_stop | input | 1 | Two stop bits instead of one |
| listen_en | input | 1 | Monitor only, never pull the line |
| tx_valid | input | 1 | Byte offered for sending |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Byte is taken at this edge if tx_valid is high |
| rx_valid | output | 1 | One-cycle pulse: received byte available |
| rx_data | output | 8 | Received byte |
| rx_parity_err | output | 1 | Parity mismatch on the received byte |
| rx_frame_err | output | 1 | Stop bit of the received byte was low |
| collision | output | 1 | One-cycle pulse: readback mismatch, byte dropped |
| line_break | output | 1 | One-cycle pulse: low level of a character time |
| line_in | input | 1 | Level read from the shared wire |
| line_pull_low | output | 1 | 1 pulls the shared wire low, 0 releases it |

## Verification
The assertions check on every cycle that listen mode keeps the line released, that the line is free whenever `tx_ready` is high, that an accepted byte starts with a pulled start bit, that a collision releases the line at once and pulses for one cycle only, and that no byte is delivered during a break or while the block is pulling the line. Bit order, parity values, echo suppression over a whole frame, the one-character idle gate, break length against the all-zero byte, framing errors and the preset bit times can only be shown by the bench. It does this by playing a second node on the wire and decoding the block's own frames at mid-bit.

// File: rtl/swu_pkg.sv
package swu_pkg;

    parameter int DATA_W = 8;
    parameter int DIV_W  = 16;
    parameter int SYNC_N = 2;

    localparam int NBITS_MAX = DATA_W + 4;
    localparam int CNT_W     = $clog2(NBITS_MAX + 1);
    localparam int CHAR_W    = DIV_W + CNT_W;

    localparam int BAUD_LIN_SLOW = 9600;
    localparam int BAUD_LIN_FAST = 19200;
    localparam int BAUD_KLINE    = 10400;

    typedef struct packed {
        logic [DIV_W-1:0] bit_ticks;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
        logic             listen;
    } line_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_word_t;

    typedef enum logic {TX_IDLE, TX_SEND} tx_st_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_st_t;

    function automatic logic [DIV_W-1:0] preset_ticks(input int clk_hz, input int baud);
        return DIV_W'((clk_hz + baud / 2) / baud);
    endfunction

    function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(input logic pe, input logic ts);
        return CNT_W'(DATA_W + 2) + CNT_W'(pe) + CNT_W'(ts);
    endfunction

    function automatic logic [CHAR_W-1:0] char_time(input line_cfg_t c);
        return CHAR_W'(c.bit_ticks) * CHAR_W'(frame_len(c.par_en, c.two_stop));
    endfunction

    // Bit 0 is the start bit; unused upper positions stay high (stop level).
    function automatic logic [NBITS_MAX-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                         input line_cfg_t c);
        logic [NBITS_MAX-1:0] f;
        f           = '1;
        f[0]        = 1'b0;
        f[DATA_W:1] = d;
        if (c.par_en) f[DATA_W+1] = par_bit(d, c.par_odd);
        return f;
    endfunction

endpackage

// File: rtl/swu_sync.sv
module swu_sync import swu_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_s,
    output logic fell
);
    logic [SYNC_N-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            prev <= 1'b1;
        end else begin
            sh   <= {sh[SYNC_N-2:0], line_in};
            prev <= sh[SYNC_N-1];
        end
    end

    assign line_s = sh[SYNC_N-1];
    assign fell   = prev & ~sh[SYNC_N-1];
endmodule

// File: rtl/swu_linemon.sv
module swu_linemon import swu_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_s,
    input  logic [CHAR_W-1:0] char_cyc,
    output logic              idle_ok,
    output logic              brk
);
    logic [CHAR_W-1:0] hi_cnt;
    logic [CHAR_W-1:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
            brk    <= 1'b0;
        end else begin
            brk <= 1'b0;
            if (line_s) begin
                lo_cnt <= '0;
                if (hi_cnt < char_cyc) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
                if (lo_cnt < char_cyc) begin
                    lo_cnt <= lo_cnt + 1'b1;
                    brk    <= (CHAR_W'(lo_cnt + 1'b1) == char_cyc);
                end
            end
        end
    end

    assign idle_ok = (hi_cnt >= char_cyc);
endmodule

// File: rtl/swu_tx.sv
module swu_tx import swu_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  line_cfg_t         cfg,
    input  logic              idle_ok,
    input  logic              line_s,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              pull_low,
    output logic              busy,
    output logic              coll
);
    tx_st_t               st;
    logic [NBITS_MAX-1:0] sr;
    logic [CNT_W-1:0]     left;
    logic [DIV_W-1:0]     tmr;
    logic [DIV_W-1:0]     half;

    assign half     = cfg.bit_ticks >> 1;
    assign tx_ready = (st == TX_IDLE) && idle_ok && !cfg.listen;
    assign busy     = (st == TX_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= TX_IDLE;
            sr       <= '1;
            left     <= '0;
            tmr      <= '0;
            pull_low <= 1'b0;
            coll     <= 1'b0;
        end else begin
            coll <= 1'b0;
            case (st)
                TX_IDLE: begin
                    pull_low <= 1'b0;
                    if (tx_valid && tx_ready) begin
                        sr       <= build_frame(tx_data, cfg);
                        left     <= frame_len(cfg.par_en, cfg.two_stop);
                        tmr      <= '0;
                        pull_low <= 1'b1;
                        st       <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (cfg.listen) begin
                        pull_low <= 1'b0;
                        st       <= TX_IDLE;
                    end else if (tmr == half && line_s != sr[0]) begin
                        coll     <= 1'b1;
                        pull_low <= 1'b0;
                        st       <= TX_IDLE;
                    end else if (tmr == cfg.bit_ticks - 1'b1) begin
                        tmr  <= '0;
                        sr   <= {1'b1, sr[NBITS_MAX-1:1]};
                        left <= left - 1'b1;
                        if (left == CNT_W'(1)) begin
                            pull_low <= 1'b0;
                            st       <= TX_IDLE;
                        end else begin
                            pull_low <= ~sr[1];
                        end
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/swu_rx.sv
module swu_rx import swu_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] ticks,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             line_s,
    input  logic             fell,
    input  logic             brk,
    input  logic             tx_busy,
    output logic             rx_valid,
    output rx_word_t         rx_word
);
    rx_st_t            st;
    logic [DIV_W-1:0]  tmr;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] dat;
    logic              pbit;
    logic              echo;
    logic [DIV_W-1:0]  half;
    logic [CNT_W-1:0]  last_idx;
    logic              perr_now;

    assign half     = ticks >> 1;
    assign last_idx = CNT_W'(DATA_W) + CNT_W'(par_en);
    assign perr_now = par_en && (par_bit(dat, par_odd) != pbit);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RX_IDLE;
            tmr      <= '0;
            cnt      <= '0;
            dat      <= '0;
            pbit     <= 1'b0;
            echo     <= 1'b0;
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else begin
            rx_valid <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (fell) begin
                        st   <= RX_START;
                        tmr  <= '0;
                        echo <= tx_busy;
                    end
                end
                RX_START: begin
                    if (tmr == half - 1'b1) begin
                        tmr <= '0;
                        cnt <= '0;
                        st  <= line_s ? RX_IDLE : RX_BITS;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (tmr == ticks - 1'b1) begin
                        tmr <= '0;
                        if (cnt == last_idx) begin
                            if (line_s) begin
                                rx_valid <= !echo;
                                rx_word  <= '{data: dat, perr: perr_now, ferr: 1'b0};
                                st       <= RX_IDLE;
                            end else begin
                                st <= RX_HOLD;
                            end
                        end else begin
                            if (cnt < CNT_W'(DATA_W)) dat <= {line_s, dat[DATA_W-1:1]};
                            else                      pbit <= line_s;
                            cnt <= cnt + 1'b1;
                        end
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (brk) begin
                        st <= RX_IDLE;
                    end else if (line_s) begin
                        rx_valid <= !echo;
                        rx_word  <= '{data: dat, perr: perr_now, ferr: 1'b1};
                        st       <= RX_IDLE;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/swu_top.sv
module swu_top import swu_pkg::*; #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        baud_sel,
    input  logic [DIV_W-1:0]  custom_ticks,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              listen_en,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_parity_err,
    output logic              rx_frame_err,
    output logic              collision,
    output logic              line_break,
    input  logic              line_in,
    output logic              line_pull_low
);
    localparam logic [DIV_W-1:0] TICKS_SLOW  = preset_ticks(CLK_HZ, BAUD_LIN_SLOW);
    localparam logic [DIV_W-1:0] TICKS_FAST  = preset_ticks(CLK_HZ, BAUD_LIN_FAST);
    localparam logic [DIV_W-1:0] TICKS_KLINE = preset_ticks(CLK_HZ, BAUD_KLINE);

    line_cfg_t         cfg;
    logic [DIV_W-1:0]  ticks;
    logic [CHAR_W-1:0] char_cyc;
    logic              line_s, fell, idle_ok, tx_busy;
    rx_word_t          rx_word;

    always_comb begin
        case (baud_sel)
            2'd0:    ticks = TICKS_SLOW;
            2'd1:    ticks = TICKS_FAST;
            2'd2:    ticks = TICKS_KLINE;
            default: ticks = custom_ticks;
        endcase
    end

    assign cfg      = '{bit_ticks: ticks, par_en: par_en, par_odd: par_odd,
                        two_stop: two_stop, listen: listen_en};
    assign char_cyc = char_time(cfg);

    swu_sync u_sync (
        .clk(clk), .rst(rst), .line_in(line_in), .line_s(line_s), .fell(fell)
    );

    swu_linemon u_mon (
        .clk(clk), .rst(rst), .line_s(line_s), .char_cyc(char_cyc),
        .idle_ok(idle_ok), .brk(line_break)
    );

    swu_tx u_tx (
        .clk(clk), .rst(rst), .cfg(cfg), .idle_ok(idle_ok), .line_s(line_s),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .pull_low(line_pull_low), .busy(tx_busy), .coll(collision)
    );

    swu_rx u_rx (
        .clk(clk), .rst(rst), .ticks(ticks), .par_en(par_en), .par_odd(par_odd),
        .line_s(line_s), .fell(fell), .brk(line_break), .tx_busy(tx_busy),
        .rx_valid(rx_valid), .rx_word(rx_word)
    );

    assign rx_data       = rx_word.data;
    assign rx_parity_err = rx_word.perr;
    assign rx_frame_err  = rx_word.ferr;
endmodule

// File: rtl/swu_chk.sv
module swu_chk (
    input logic clk,
    input logic rst,
    input logic listen_en,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic collision,
    input logic line_break,
    input logic line_pull_low
);
    // R9
    listen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (listen_en && $past(listen_en)) |-> !line_pull_low);

    // R8
    ready_line_free_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !line_pull_low);

    // R1
    start_pull_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> line_pull_low);

    // R7
    coll_release_chk: assert property (@(posedge clk) disable iff (rst)
        collision |-> !line_pull_low);

    // R7
    coll_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        collision |=> !collision);

    // R5
    break_no_byte_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && line_break));

    // R6
    no_rx_while_pull_chk: assert property (@(posedge clk) disable iff (rst)
        line_pull_low |-> !rx_valid);
endmodule

bind swu_top swu_chk u_chk (
    .clk(clk), .rst(rst), .listen_en(listen_en), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .collision(collision),
    .line_break(line_break), .line_pull_low(line_pull_low)
);

// File: tb/tb_swu_top.sv
module tb_swu_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 153600;   // 9600 -> 16, 19200 -> 8, 10400 -> 15

    // table: data[10:3], par_en[2], par_odd[1], two_stop[0]
    localparam int NVEC = 6;
    localparam logic [10:0] VEC [NVEC] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0},
        {8'h00, 1'b0, 1'b0, 1'b0},
        {8'hFF, 1'b1, 1'b0, 1'b0},
        {8'h3C, 1'b1, 1'b1, 1'b0},
        {8'h81, 1'b1, 1'b0, 1'b1},
        {8'h7E, 1'b1, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]  baud_sel = 2'd0;
    logic [15:0] custom_ticks = 16'd12;
    logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, listen_en = 1'b0;
    logic tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic tgt_pull = 1'b0;
    logic tx_ready, rx_valid, rx_parity_err, rx_frame_err, collision, line_break;
    logic line_pull_low, line;
    logic [7:0] rx_data;

    assign line = ~(line_pull_low | tgt_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    swu_top #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst(rst), .baud_sel(baud_sel), .custom_ticks(custom_ticks),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop), .listen_en(listen_en),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .collision(collision), .line_break(line_break),
        .line_in(line), .line_pull_low(line_pull_low)
    );

    int rx_cnt = 0, coll_cnt = 0, brk_cnt = 0, pull_cnt = 0;
    logic [7:0] got_data = 8'h00;
    logic got_perr = 1'b0, got_ferr = 1'b0;

    always_ff @(posedge clk) begin
        if (rx_valid) begin
            rx_cnt   <= rx_cnt + 1;
            got_data <= rx_data;
            got_perr <= rx_parity_err;
            got_ferr <= rx_frame_err;
        end
        if (collision)     coll_cnt <= coll_cnt + 1;
        if (line_break)    brk_cnt  <= brk_cnt + 1;
        if (line_pull_low) pull_cnt <= pull_cnt + 1;
    end

    int n_tests = 0, n_fail = 0;
    int bt = 16;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // second node on the wire
    task automatic tgt_send(input logic [7:0] d, input bit pe, input bit po,
                            input bit flip_par, input bit bad_stop, input bit ts);
        @(negedge clk);
        tgt_pull = 1'b1;
        wait_neg(bt);
        for (int i = 0; i < 8; i++) begin
            tgt_pull = ~d[i];
            wait_neg(bt);
        end
        if (pe) begin
            tgt_pull = ~((^d) ^ po ^ flip_par);
            wait_neg(bt);
        end
        tgt_pull = bad_stop;
        wait_neg(bt);
        tgt_pull = 1'b0;
        if (ts) wait_neg(bt);
    endtask

    task automatic recv_check(input string req, input logic [7:0] d, input bit pe,
                              input bit po, input bit flip_par, input bit bad_stop,
                              input bit ts);
        int r0, b0;
        r0 = rx_cnt; b0 = brk_cnt;
        par_en = pe; par_odd = po; two_stop = ts;
        tgt_send(d, pe, po, flip_par, bad_stop, ts);
        wait_neg(bt);
        chk(req, "rx count", rx_cnt - r0, 1);
        chk(req, "rx data", got_data, d);
        chk(req, "parity err", got_perr, flip_par);
        chk(req, "frame err", got_ferr, bad_stop);
        chk(req, "no break", brk_cnt - b0, 0);
    endtask

    task automatic wait_ready(input string req);
        for (int k = 0; k < 64 * bt && !tx_ready; k++) @(negedge clk);
        chk(req, "tx_ready reached", tx_ready, 1);
    endtask

    task automatic dut_tx_check(input string req, input logic [7:0] d, input bit pe,
                                input bit po, input bit ts);
        logic [11:0] expf, gotf;
        int n, r0;
        par_en = pe; par_odd = po; two_stop = ts;
        wait_ready(req);
        n = 10 + int'(pe) + int'(ts);
        expf = '1;
        expf[0] = 1'b0;
        expf[8:1] = d;
        if (pe) expf[9] = (^d) ^ po;
        gotf = '1;
        r0 = rx_cnt;
        tx_valid = 1'b1; tx_data = d;
        @(negedge clk);
        tx_valid = 1'b0;
        wait_neg(bt / 2);
        for (int i = 0; i < n; i++) begin
            gotf[i] = line;
            if (i != n - 1) wait_neg(bt);
        end
        chk(req, "line frame", gotf, expf);
        wait_neg(2 * bt);
        chk("R6", "own frame not received", rx_cnt - r0, 0);
    endtask

    initial begin
        int c0, b0, r0, p0;
        logic [7:0] d;
        logic pe, po, ts;
        wait_neg(5);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "line released", line_pull_low, 0);
        chk("R11", "tx_ready low", tx_ready, 0);
        chk("R11", "no rx", rx_cnt, 0);
        chk("R11", "no collision", coll_cnt, 0);
        chk("R11", "no break", brk_cnt, 0);
        // R8 gate still closed part way through first character time
        wait_neg(5 * bt);
        chk("R8", "ready held after reset", tx_ready, 0);

        // R3 R2 table of received frames (R5 boundary: 0x00 is not a break)
        for (int i = 0; i < NVEC; i++) begin
            {d, pe, po, ts} = VEC[i];
            recv_check("R3", d, pe, po, 1'b0, 1'b0, ts);
        end

        // R8 idle gate after foreign traffic
        par_en = 0; par_odd = 0; two_stop = 0;
        tgt_send(8'h55, 0, 0, 0, 0, 0);
        wait_neg(2);
        chk("R8", "ready low right after foreign byte", tx_ready, 0);
        wait_neg(11 * bt);
        chk("R8", "ready high after idle character", tx_ready, 1);

        // R1 R2 sending, several formats
        dut_tx_check("R1", 8'hA5, 0, 0, 0);
        dut_tx_check("R2", 8'h00, 1, 0, 0);
        dut_tx_check("R2", 8'h3C, 1, 1, 1);
        dut_tx_check("R1", 8'hC1, 0, 0, 1);

        // R2 parity error detection
        recv_check("R2", 8'h96, 1, 0, 1'b1, 1'b0, 0);
        recv_check("R2", 8'h96, 1, 1, 1'b1, 1'b0, 0);

        // R4 framing error
        recv_check("R4", 8'h55, 0, 0, 1'b0, 1'b1, 0);

        // R5 break
        par_en = 0; two_stop = 0;
        r0 = rx_cnt; b0 = brk_cnt;
        @(negedge clk);
        tgt_pull = 1'b1;
        wait_neg(12 * bt);
        tgt_pull = 1'b0;
        wait_neg(2 * bt);
        chk("R5", "break pulse", brk_cnt - b0, 1);
        chk("R5", "no byte for break", rx_cnt - r0, 0);

        // R7 collision: send 0xFF, other node pulls during data bit 1
        wait_ready("R7");
        c0 = coll_cnt; r0 = rx_cnt;
        tx_valid = 1'b1; tx_data = 8'hFF;
        @(negedge clk);
        tx_valid = 1'b0;
        wait_neg(2 * bt - 1);
        tgt_pull = 1'b1;
        wait_neg(bt);
        tgt_pull = 1'b0;
        chk("R7", "collision pulse", coll_cnt - c0, 1);
        chk("R7", "line released", line_pull_low, 0);
        wait_neg(12 * bt);
        chk("R7", "aborted byte not received", rx_cnt - r0, 0);
        chk("R7", "no further pulse", coll_cnt - c0, 1);

        // R9 listen mode
        listen_en = 1'b1;
        wait_neg(12 * bt);
        chk("R9", "tx_ready low in listen", tx_ready, 0);
        p0 = pull_cnt;
        tx_valid = 1'b1; tx_data = 8'h00;
        wait_neg(3 * bt);
        tx_valid = 1'b0;
        recv_check("R9", 8'h5A, 0, 0, 0, 0, 0);
        chk("R9", "never pulled", pull_cnt - p0, 0);
        listen_en = 1'b0;
        wait_ready("R9");
        tx_valid = 1'b1; tx_data = 8'h00;
        @(negedge clk);
        tx_valid = 1'b0;
        wait_neg(3 * bt);
        listen_en = 1'b1;
        wait_neg(2);
        chk("R9", "released after listen rises", line_pull_low, 0);
        p0 = pull_cnt;
        wait_neg(8 * bt);
        chk("R9", "stays released", pull_cnt - p0, 0);
        listen_en = 1'b0;
        wait_neg(12 * bt);

        // R10 bit-time selection
        baud_sel = 2'd1; bt = 8;
        recv_check("R10", 8'hC3, 0, 0, 0, 0, 0);
        dut_tx_check("R10", 8'h69, 0, 0, 0);
        baud_sel = 2'd2; bt = 15;
        recv_check("R10", 8'h2D, 1, 0, 0, 0, 0);
        baud_sel = 2'd3; bt = 12;
        wait_neg(12 * bt);
        recv_check("R10", 8'h96, 0, 0, 0, 0, 0);
        dut_tx_check("R10", 8'hE7, 1, 1, 0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 150000; k++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule